// File: doc/BRIEF.md
# Victim Line Buffer

This block sits beside a direct-mapped cache and keeps a handful of lines that the cache has recently thrown out. It is consulted only when the main cache misses. In the same request the main cache presents two things: the line address it failed to find, and the line it is about to displace from the indexed set. Every entry is compared against the requested address in parallel. Each entry has its own tag register, and that tag holds the full line address, index bits included.

If the requested line is found, the request becomes a swap. The buffer returns the stored line and its dirty flag one cycle later, and the displaced line takes over the slot that was just emptied. A conflict miss in the main cache is therefore served without going to memory.

If the requested line is not found, the displaced line is stored. It goes into a free slot when one exists; otherwise it overwrites the entry that was inserted longest ago. An overwritten entry that is dirty is sent on the write-out port toward the next lower level. A clean one is discarded.

Top module: `victim_buf`

## Requirements
- R1: After reset, rsp_valid_o and wb_valid_o are low and the buffer holds no line, so the first lookup misses.
- R2: Each cycle with req_valid_i high produces rsp_valid_o high in the next cycle. A cycle without a request produces rsp_valid_o low in the next cycle.
- R3: A lookup hits only when a stored line address equals req_addr_i in every bit. On a hit, rsp_hit_o is 1 and rsp_data_o and rsp_dirty_o carry that line's data and dirty flag.
- R4: On a hit with dsp_valid_i high, the hit line leaves the buffer, so a later lookup of it misses. The displaced line is stored in its place.
- R5: On a hit with dsp_valid_i low, the hit entry is freed and nothing is written out.
- R6: On a miss with dsp_valid_i high while a slot is free, the displaced line is stored and wb_valid_o stays low.
- R7: On a miss with dsp_valid_i high while all slots are full, the line that was inserted earliest is overwritten. A line that entered by a swap counts as the most recent insertion.
- R8: An overwritten line that is dirty appears on wb_valid_o, wb_addr_o and wb_data_o in the cycle after the request. An overwritten clean line leaves wb_valid_o low.
- R9: A cycle with req_valid_i low changes no stored line, whatever the displaced-line inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Main cache missed; lookup request |
| req_addr_i | input | AW | Line address that missed |
| dsp_valid_i | input | 1 | A valid line is displaced from the main cache |
| dsp_addr_i | input | AW | Line address of the displaced line |
| dsp_data_i | input | DW | Data of the displaced line |
| dsp_dirty_i | input | 1 | Displaced line is modified |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Requested line was found |
| rsp_data_o | output | DW | Line data on a hit, zero otherwise |
| rsp_dirty_o | output | 1 | Dirty flag of the returned line |
| wb_valid_o | output | 1 | Dirty line leaving toward lower memory |
| wb_addr_o | output | AW | Line address of the written-out line |
| wb_data_o | output | DW | Data of the written-out line |

## Verification
The assertions assume that the displaced line address is never already held in the buffer and never equals the requested address. This is true when the main cache and the buffer hold disjoint sets of lines. Under that assumption, at most one entry can match, and the assertion that a hit is unique is meaningful.

The stimulus respects this by drawing each displaced address from a small pool and retrying until the address is absent from the bench's own record of the buffer contents and differs from the lookup address. Because the pool is small, hits, swaps, fills and dirty overwrites all occur often.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int unsigned VB_ENTRIES = 4;
  localparam int unsigned VB_ADDR_W  = 26;
  localparam int unsigned VB_LINE_W  = 64;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PROBE,   // miss, nothing to insert
    ACT_SWAP,    // hit, displaced line takes the slot
    ACT_TAKE,    // hit, slot freed
    ACT_FILL,    // miss, insert into free slot
    ACT_REPLACE  // miss, overwrite oldest
  } vb_act_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]        addr_i,
  output logic [N-1:0]         hit_o,
  output logic                 hit_any_o,
  output logic [IW-1:0]        hit_idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tag_i[g] == addr_i);
  end

  assign hit_any_o = |hit_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_o[i]) hit_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic          upd_i,
  input  logic [IW-1:0] slot_i,
  output logic          free_any_o,
  output logic [IW-1:0] free_idx_o,
  output logic [IW-1:0] old_idx_o
);
  // rank 0 = most recent insertion; ranks always form a permutation
  logic [N-1:0][IW-1:0] rank_q;
  logic [IW-1:0]        slot_rank;

  assign slot_rank = rank_q[slot_i];

  for (genvar g = 0; g < N; g++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[g] <= IW'(g);
      end else if (upd_i) begin
        if (slot_i == IW'(g))          rank_q[g] <= '0;
        else if (rank_q[g] < slot_rank) rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    free_any_o = 1'b0;
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any_o = 1'b1;
        free_idx_o = IW'(i);
      end
    end
  end

  always_comb begin
    old_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_q[i] == IW'(N - 1)) old_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26,
  parameter int unsigned DW = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_slot_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 wr_dirty_i,
  input  logic                 inv_en_i,
  input  logic [IW-1:0]        inv_slot_i,
  output logic [N-1:0]         valid_o,
  output logic [N-1:0]         dirty_o,
  output logic [N-1:0][AW-1:0] tag_o,
  output logic [N-1:0][DW-1:0] data_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wr_me, inv_me;
    assign wr_me  = wr_en_i  && (wr_slot_i  == IW'(g));
    assign inv_me = inv_en_i && (inv_slot_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        dirty_o[g] <= 1'b0;
        tag_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (wr_me) begin
        valid_o[g] <= 1'b1;
        dirty_o[g] <= wr_dirty_i;
        tag_o[g]   <= wr_addr_i;
        data_o[g]  <= wr_data_i;
      end else if (inv_me) begin
        valid_o[g] <= 1'b0;
        dirty_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import vb_pkg::*;
#(
  parameter int unsigned N  = VB_ENTRIES,
  parameter int unsigned AW = VB_ADDR_W,
  parameter int unsigned DW = VB_LINE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          dsp_valid_i,
  input  logic [AW-1:0] dsp_addr_i,
  input  logic [DW-1:0] dsp_data_i,
  input  logic          dsp_dirty_i,
  output logic          rsp_valid_o,
  output logic          rsp_hit_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          rsp_dirty_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]         valid_vec, dirty_vec, hit_vec;
  logic [N-1:0][AW-1:0] tag_vec;
  logic [N-1:0][DW-1:0] data_vec;
  logic                 hit_any, free_any, ins_en, inv_en;
  logic [IW-1:0]        hit_idx, free_idx, old_idx, ins_slot;
  vb_act_e              act;

  vb_match #(.N(N), .AW(AW)) u_match (
    .valid_i   (valid_vec),
    .tag_i     (tag_vec),
    .addr_i    (req_addr_i),
    .hit_o     (hit_vec),
    .hit_any_o (hit_any),
    .hit_idx_o (hit_idx)
  );

  always_comb begin
    act = ACT_IDLE;
    if (req_valid_i) begin
      if (hit_any)          act = dsp_valid_i ? ACT_SWAP : ACT_TAKE;
      else if (!dsp_valid_i) act = ACT_PROBE;
      else                  act = free_any ? ACT_FILL : ACT_REPLACE;
    end
  end

  always_comb begin
    unique case (act)
      ACT_SWAP, ACT_TAKE: ins_slot = hit_idx;
      ACT_FILL:           ins_slot = free_idx;
      default:            ins_slot = old_idx;
    endcase
  end

  assign ins_en = (act == ACT_SWAP) || (act == ACT_FILL) || (act == ACT_REPLACE);
  assign inv_en = (act == ACT_TAKE);

  vb_age #(.N(N)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_vec),
    .upd_i      (ins_en),
    .slot_i     (ins_slot),
    .free_any_o (free_any),
    .free_idx_o (free_idx),
    .old_idx_o  (old_idx)
  );

  vb_store #(.N(N), .AW(AW), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ins_en),
    .wr_slot_i  (ins_slot),
    .wr_addr_i  (dsp_addr_i),
    .wr_data_i  (dsp_data_i),
    .wr_dirty_i (dsp_dirty_i),
    .inv_en_i   (inv_en),
    .inv_slot_i (hit_idx),
    .valid_o    (valid_vec),
    .dirty_o    (dirty_vec),
    .tag_o      (tag_vec),
    .data_o     (data_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_data_o  <= '0;
      rsp_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && hit_any;
      rsp_data_o  <= (req_valid_i && hit_any) ? data_vec[hit_idx] : '0;
      rsp_dirty_o <= req_valid_i && hit_any && dirty_vec[hit_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_addr_o  <= '0;
      wb_data_o  <= '0;
    end else begin
      wb_valid_o <= (act == ACT_REPLACE) && dirty_vec[old_idx];
      wb_addr_o  <= tag_vec[old_idx];
      wb_data_o  <= data_vec[old_idx];
    end
  end
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         dsp_valid_i,
  input logic         rsp_valid_o,
  input logic         rsp_hit_o,
  input logic         wb_valid_o,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_vec,
  input logic         free_any
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_single_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_no_wb_on_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> rsp_valid_o && !rsp_hit_o);

  assert_fill_adds_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dsp_valid_i && !(|hit_vec) && free_any)
      |=> $countones(valid_vec) == $countones($past(valid_vec)) + 1);

  assert_wb_needs_insert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(dsp_valid_i) && $past(req_valid_i));

  assert_idle_keeps_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(valid_vec));
endmodule

bind victim_buf vb_checker #(.N(N)) i_vb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .dsp_valid_i (dsp_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .wb_valid_o  (wb_valid_o),
  .hit_vec     (hit_vec),
  .valid_vec   (valid_vec),
  .free_any    (free_any)
);

// File: tb/test_victim_buf.sv
module test_victim_buf;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic          dsp_valid_i = 1'b0;
  logic [AW-1:0] dsp_addr_i = '0;
  logic [DW-1:0] dsp_data_i = '0;
  logic          dsp_dirty_i = 1'b0;
  logic          rsp_valid_o, rsp_hit_o, rsp_dirty_o, wb_valid_o;
  logic [DW-1:0] rsp_data_o, wb_data_o;
  logic [AW-1:0] wb_addr_o;

  always #5 clk_i = ~clk_i;

  victim_buf #(.N(N), .AW(AW), .DW(DW)) i_victim_buf (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench record of buffer contents, ordered by insertion stamp
  bit            mv [N];
  logic [AW-1:0] ma [N];
  logic [DW-1:0] md [N];
  bit            mdy[N];
  int            ms [N];
  int            stamp = 0;

  task automatic chk(string r, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  function automatic int earliest();
    int o = 0;
    for (int i = 1; i < N; i++) if (ms[i] < ms[o]) o = i;
    return o;
  endfunction

  task automatic put(int s, logic [AW-1:0] a, logic [DW-1:0] d, bit dy);
    mv[s] = 1'b1; ma[s] = a; md[s] = d; mdy[s] = dy; ms[s] = stamp; stamp++;
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic req(string r, bit rv, logic [AW-1:0] ra, bit dv,
                     logic [AW-1:0] da, logic [DW-1:0] dd, bit ddy);
    bit eh = 0, ew = 0, edy = 0;
    logic [DW-1:0] ed = '0, ewd = '0;
    logic [AW-1:0] ewa = '0;
    int h, f;
    string rr;
    req_valid_i = rv; req_addr_i = ra;
    dsp_valid_i = dv; dsp_addr_i = da; dsp_data_i = dd; dsp_dirty_i = ddy;
    if (rv) begin
      h = find(ra);
      if (h >= 0) begin
        eh = 1; ed = md[h]; edy = mdy[h];
        if (dv) put(h, da, dd, ddy);
        else mv[h] = 1'b0;
      end else if (dv) begin
        f = first_free();
        if (f < 0) begin
          f = earliest();
          ew = mdy[f]; ewa = ma[f]; ewd = md[f];
        end
        put(f, da, dd, ddy);
      end
    end
    @(negedge clk_i);
    rr = r;
    if (r == "") rr = !rv ? "R9" : eh ? "R3" : ew ? "R8" : "R6";
    chk(r == "" ? "R2" : rr, "rsp_valid", DW'(rsp_valid_o), DW'(rv));
    if (rv) begin
      chk(rr, "rsp_hit", DW'(rsp_hit_o), DW'(eh));
      if (eh) begin
        chk(rr, "rsp_data", rsp_data_o, ed);
        chk(rr, "rsp_dirty", DW'(rsp_dirty_o), DW'(edy));
      end
    end
    chk(rr, "wb_valid", DW'(wb_valid_o), DW'(ew));
    if (ew) begin
      chk(rr, "wb_addr", DW'(wb_addr_o), DW'(ewa));
      chk(rr, "wb_data", wb_data_o, ewd);
    end
  endtask

  function automatic logic [AW-1:0] pick();
    return AW'($urandom_range(0, 11)) | (AW'($urandom_range(0, 1)) << 20);
  endfunction

  localparam logic [AW-1:0] A1 = 26'h100, A2 = 26'h101, A3 = 26'h102, A4 = 26'h103,
                            A5 = 26'h104, A6 = 26'h105, A7 = 26'h106, A8 = 26'h107,
                            A9 = 26'h1ff, A10 = 26'h108;

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ra, da;
    bit rv, dv;
    void'($urandom(32'h1d5c_0a17));
    for (int i = 0; i < N; i++) begin mv[i] = 0; ms[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1", "rsp_valid after reset", DW'(rsp_valid_o), '0);
    chk("R1", "wb_valid after reset", DW'(wb_valid_o), '0);
    req("R1", 1, A1, 0, '0, '0, 0);
    // fill all slots
    req("R6", 1, A9, 1, A1, 64'h1111, 1);
    req("R6", 1, A9, 1, A2, 64'h2222, 0);
    req("R6", 1, A9, 1, A3, 64'h3333, 1);
    req("R6", 1, A9, 1, A4, 64'h4444, 0);
    // take without displaced line, then slot reusable
    req("R3", 1, A2, 0, '0, '0, 0);
    req("R5", 1, A2, 1, A5, 64'h5555, 1);
    // idle request with displaced inputs set
    req("R9", 0, A1, 1, A7, 64'h7777, 1);
    req("R9", 1, A7, 0, '0, '0, 0);
    // swap
    req("R4", 1, A3, 1, A6, 64'h6666, 1);
    req("R4", 1, A3, 0, '0, '0, 0);
    req("R3", 1, A6 | (26'h1 << 25), 0, '0, '0, 0);
    // replacement in insertion order: A1, A4, A5, A6
    req("R8", 1, A9, 1, A7, 64'h7777, 0);
    req("R8", 1, A9, 1, A8, 64'h8888, 0);
    req("R7", 1, A9, 1, A10, 64'haaaa, 0);
    req("R7", 1, A6, 0, '0, '0, 0);
    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      rv = $urandom_range(0, 9) != 0;
      dv = $urandom_range(0, 4) != 0;
      ra = pick();
      do da = pick(); while (find(da) >= 0 || da == ra);
      req("", rv, ra, dv, da, {$urandom, $urandom}, 1'($urandom_range(0, 1)));
    end
    req_valid_i = 0; dsp_valid_i = 0;
    @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule